// File: doc/BRIEF.md
# Power-On Sequencer with Wake-Event Policy

This block drives the system power-on output from three sources: a configurable wake-event detector, a power button that can force the output off when held, and a supply-present input. A wake event asserts the output. A long button hold or a sustained loss of supply deasserts it. A guard mode sets a minimum off time before the output may turn on again, and it also arms the supply-loss shutdown.

When the block returns from a power failure, a wake-policy field decides what may turn the output back on. The choices are automatic turn-on when supply returns, a fresh event seen after supply is back, or an alarm-match event latched during the outage. All timing is counted in ticks of an external 1 ms enable.

Software sets the block through a small two-register write port. The registers are loaded only by the first power-up reset. The master reset clears the sequencing state and leaves the registers as they were.

Top module: `pwr_on_seq`

## Requirements
- R1: Trigger field `trig` (register 0, bits 2:0) selects the event condition: 000 low level, 001 high level, 011 falling edge, 100 rising edge, 101 either edge. Codes 010, 110 and 111 never produce an event. A level condition produces an event on every cycle it holds.
- R2: The event input passes through a two-flop synchronizer. Edges are found by comparing the synchronized sample with the sample one cycle older. With the output off and turn-on allowed, an input change driven before clock edge k shows on `pwr_on` after edge k+2.
- R3: Register 0 holds `trig` in bits 2:0, override-time select in bit 3 and guard mode in bit 4; bits 7:5 are ignored. Register 1 holds the wake option in bits 1:0 and the auto-on bit in bit 2. Register 0 loads 05h and register 1 loads 00h on `por_n` only. A master reset leaves both unchanged.
- R4: Holding the button without a break for OVR_LONG_TICKS ticks (select bit 0) or OVR_SHORT_TICKS ticks (select bit 1) deasserts `pwr_on`. The count starts on the first tick after the synchronized button goes high.
- R5: Releasing the button before the override time restarts the override count from zero.
- R6: With guard mode 0, `pwr_on` turns on again only after MIN_OFF_TICKS ticks have passed since it turned off. A request made during the lockout is held and is granted when the lockout ends.
- R7: With guard mode 1, `pwr_on` may turn on again in the cycle right after it turned off.
- R8: With guard mode 0, `pwr_on` deasserts after it has been on for VDD_LOSS_TICKS consecutive ticks with `vdd_ok` low. With guard mode 1, `vdd_ok` has no effect on `pwr_on`.
- R9: Wake option 00 during a power failure: if auto-on is 1, `pwr_on` asserts in the cycle after `vdd_ok` rises. If auto-on is 0, it stays off until the next enabled event.
- R10: Wake option 01 during a power failure: events are ignored while `vdd_ok` is low, and the return of supply alone does not turn the output on. An event seen while `vdd_ok` is high turns it on.
- R11: Wake option 10 behaves like 01, and in addition a `match_evt` seen during the failure is latched and turns the output on when `vdd_ok` rises. The latch clears whenever `pwr_fail` is low.
- R12: Wake option 11 blocks every turn-on while `pwr_fail` is high.
- R13: A master reset or power-up reset forces `pwr_on` low, clears any held request and clears the off-time lockout.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| por_n | input | 1 | First power-up reset, active low; loads registers and state |
| mrst_n | input | 1 | Master reset, active low; clears state only |
| tick_ms | input | 1 | One-cycle 1 ms timing enable |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | 1 | Register select: 0 trigger/guard, 1 wake policy |
| reg_wdata | input | 8 | Register write data |
| evt_in | input | 1 | Asynchronous wake-event input |
| btn_in | input | 1 | Asynchronous power button, high when pressed |
| vdd_ok | input | 1 | Main supply present |
| pwr_fail | input | 1 | Power-failure flag |
| match_evt | input | 1 | Alarm-match event |
| pwr_on | output | 1 | System power-on output |

## Verification
The bench checks each trigger code with the wrong-polarity stimulus as well as the right one. A decoder with a swapped case arm would then fire on the ignored edge, or stay silent on a reserved code only by chance. The button and supply-loss counts are sampled one cycle before and one cycle at the expected turn-off. An off-by-one counter, or one that is not restarted by an early release, turns off a cycle or many cycles early. The lockout test places a request inside the off window: a design that drops the request stays off, and one without a lockout turns on too soon. The power-failure tests cover each wake option with and without supply, check that the match latch clears, and check that a master reset keeps the configured trigger, override time and guard mode.

// File: rtl/pwr_on_pkg.sv
package pwr_on_pkg;

   typedef enum logic [2:0] {
      TRG_LOW   = 3'b000,
      TRG_HIGH  = 3'b001,
      TRG_RSV2  = 3'b010,
      TRG_FALL  = 3'b011,
      TRG_RISE  = 3'b100,
      TRG_BOTH  = 3'b101,
      TRG_RSV6  = 3'b110,
      TRG_RSV7  = 3'b111
   } trig_e;

   typedef enum logic [1:0] {
      WAKE_BY_AUTO_BIT  = 2'b00,
      WAKE_NEW_EVT      = 2'b01,
      WAKE_NEW_OR_MATCH = 2'b10,
      WAKE_BLOCKED      = 2'b11
   } wake_e;

   typedef struct packed {
      logic  guard;
      logic  ovr_short;
      trig_e trig;
   } ctrl_t;

   typedef struct packed {
      logic  auto_on;
      wake_e opt;
   } wake_t;

   localparam logic [7:0] CTRL_POR_VAL = 8'h05;
   localparam logic [7:0] WAKE_POR_VAL = 8'h00;

   function automatic logic trig_is_reserved(input trig_e t);
      return (t == TRG_RSV2) || (t == TRG_RSV6) || (t == TRG_RSV7);
   endfunction

endpackage

// File: rtl/pwr_on_regs.sv
module pwr_on_regs
   import pwr_on_pkg::*;
(
   input  logic       clk,
   input  logic       por_n,
   input  logic       mrst_n,
   input  logic       reg_wr_en,
   input  logic       reg_addr,
   input  logic [7:0] reg_wdata,
   output ctrl_t      ctrl,
   output wake_t      wake
);

   ctrl_t ctrl_q;
   wake_t wake_q;

   // Only the first power-up reset loads these; master reset is not wired in.
   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n) begin
         ctrl_q <= ctrl_t'(CTRL_POR_VAL[4:0]);
      end else if (reg_wr_en && !reg_addr) begin
         ctrl_q <= ctrl_t'(reg_wdata[4:0]);
      end
   end

   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n) begin
         wake_q <= wake_t'(WAKE_POR_VAL[2:0]);
      end else if (reg_wr_en && reg_addr) begin
         wake_q <= wake_t'(reg_wdata[2:0]);
      end
   end

   assign ctrl = ctrl_q;
   assign wake = wake_q;

   // R3: master reset with no write leaves the configuration untouched
   assert_cfg_kept_on_mrst_R3: assert property (@(posedge clk) disable iff (!por_n)
      (!mrst_n && !reg_wr_en) |=> ($stable(ctrl_q) && $stable(wake_q)));

endmodule

// File: rtl/pwr_on_sync.sv
module pwr_on_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("pwr_on_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES-1:0] ff;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ff <= '0;
      else        ff <= {ff[STAGES-2:0], d};
   end

   assign q = ff[STAGES-1];

endmodule

// File: rtl/pwr_on_evt_det.sv
module pwr_on_evt_det
   import pwr_on_pkg::*;
(
   input  logic  clk,
   input  logic  rst_n,
   input  logic  s_cur,
   input  trig_e mode,
   output logic  hit
);

   logic s_prev;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) s_prev <= 1'b0;
      else        s_prev <= s_cur;
   end

   logic rise, fall;
   assign rise = s_cur & ~s_prev;
   assign fall = ~s_cur & s_prev;

   always_comb begin
      unique case (mode)
         TRG_LOW:  hit = ~s_cur;
         TRG_HIGH: hit = s_cur;
         TRG_FALL: hit = fall;
         TRG_RISE: hit = rise;
         TRG_BOTH: hit = rise | fall;
         default:  hit = 1'b0;
      endcase
   end

   // R1: reserved trigger codes are silent
   assert_reserved_silent_R1: assert property (@(posedge clk) disable iff (!rst_n)
      trig_is_reserved(mode) |-> !hit);

endmodule

// File: rtl/pwr_on_tick_timer.sv
module pwr_on_tick_timer #(
   parameter  int MAX_TICKS = 4000,
   localparam int W         = $clog2(MAX_TICKS + 1)
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr,
   input  logic         tick,
   input  logic [W-1:0] limit,
   output logic         hit,
   output logic         done
);

   generate
      if (MAX_TICKS < 2) begin : g_bad_max
         $error("pwr_on_tick_timer: MAX_TICKS must be at least 2");
      end
   endgenerate

   logic [W-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                           cnt <= '0;
      else if (clr)                         cnt <= '0;
      else if (tick && (cnt < limit))       cnt <= cnt + 1'b1;
   end

   assign hit  = tick && !clr && (cnt == limit - 1'b1);
   assign done = (cnt >= limit);

endmodule

// File: rtl/pwr_on_seq.sv
module pwr_on_seq
   import pwr_on_pkg::*;
#(
   parameter int OVR_LONG_TICKS  = 4000,
   parameter int OVR_SHORT_TICKS = 3950,
   parameter int VDD_LOSS_TICKS  = 500,
   parameter int MIN_OFF_TICKS   = 1000,
   parameter int SYNC_STAGES     = 2
) (
   input  logic       clk,
   input  logic       por_n,
   input  logic       mrst_n,
   input  logic       tick_ms,
   input  logic       reg_wr_en,
   input  logic       reg_addr,
   input  logic [7:0] reg_wdata,
   input  logic       evt_in,
   input  logic       btn_in,
   input  logic       vdd_ok,
   input  logic       pwr_fail,
   input  logic       match_evt,
   output logic       pwr_on
);

   localparam int OVR_W  = $clog2(OVR_LONG_TICKS + 1);
   localparam int LOSS_W = $clog2(VDD_LOSS_TICKS + 1);
   localparam int OFF_W  = $clog2(MIN_OFF_TICKS + 1);

   generate
      if (OVR_SHORT_TICKS >= OVR_LONG_TICKS) begin : g_bad_ovr
         $error("pwr_on_seq: short override must be below long override");
      end
      if (VDD_LOSS_TICKS < 2 || MIN_OFF_TICKS < 2) begin : g_bad_time
         $error("pwr_on_seq: timing limits must be at least 2 ticks");
      end
   endgenerate

   logic sys_rst_n;
   assign sys_rst_n = por_n & mrst_n;

   // ---------------- configuration ----------------
   ctrl_t ctrl;
   wake_t wake;

   pwr_on_regs u_regs (
      .clk       (clk),
      .por_n     (por_n),
      .mrst_n    (mrst_n),
      .reg_wr_en (reg_wr_en),
      .reg_addr  (reg_addr),
      .reg_wdata (reg_wdata),
      .ctrl      (ctrl),
      .wake      (wake)
   );

   // ---------------- input conditioning ----------------
   logic evt_s, btn_s;

   pwr_on_sync #(.STAGES(SYNC_STAGES)) u_evt_sync (
      .clk (clk), .rst_n (sys_rst_n), .d (evt_in), .q (evt_s)
   );

   pwr_on_sync #(.STAGES(SYNC_STAGES)) u_btn_sync (
      .clk (clk), .rst_n (sys_rst_n), .d (btn_in), .q (btn_s)
   );

   logic evt_hit;

   pwr_on_evt_det u_evt_det (
      .clk   (clk),
      .rst_n (sys_rst_n),
      .s_cur (evt_s),
      .mode  (ctrl.trig),
      .hit   (evt_hit)
   );

   // ---------------- timers ----------------
   logic       on_q;
   logic       ovr_fire, ovr_done;
   logic       loss_fire_raw, loss_done;
   logic       off_done, off_hit;
   logic [OVR_W-1:0] ovr_limit;

   assign ovr_limit = ctrl.ovr_short ? OVR_W'(OVR_SHORT_TICKS) : OVR_W'(OVR_LONG_TICKS);

   pwr_on_tick_timer #(.MAX_TICKS(OVR_LONG_TICKS)) u_ovr_tmr (
      .clk   (clk),
      .rst_n (sys_rst_n),
      .clr   (!btn_s),
      .tick  (tick_ms),
      .limit (ovr_limit),
      .hit   (ovr_fire),
      .done  (ovr_done)
   );

   logic loss_clr;
   assign loss_clr = ctrl.guard || !on_q || vdd_ok;

   pwr_on_tick_timer #(.MAX_TICKS(VDD_LOSS_TICKS)) u_loss_tmr (
      .clk   (clk),
      .rst_n (sys_rst_n),
      .clr   (loss_clr),
      .tick  (tick_ms),
      .limit (LOSS_W'(VDD_LOSS_TICKS)),
      .hit   (loss_fire_raw),
      .done  (loss_done)
   );

   pwr_on_tick_timer #(.MAX_TICKS(MIN_OFF_TICKS)) u_off_tmr (
      .clk   (clk),
      .rst_n (sys_rst_n),
      .clr   (on_q),
      .tick  (tick_ms),
      .limit (OFF_W'(MIN_OFF_TICKS)),
      .hit   (off_hit),
      .done  (off_done)
   );

   // ---------------- power-failure policy ----------------
   logic vdd_q, match_lat;

   always_ff @(posedge clk or negedge sys_rst_n) begin
      if (!sys_rst_n) begin
         vdd_q     <= 1'b1;
         match_lat <= 1'b0;
      end else begin
         vdd_q     <= vdd_ok;
         match_lat <= pwr_fail && (match_lat || match_evt);
      end
   end

   logic vdd_rise;
   assign vdd_rise = vdd_ok && !vdd_q;

   logic evt_accept, auto_req, block_all;

   always_comb begin
      evt_accept = 1'b0;
      auto_req   = 1'b0;
      block_all  = 1'b0;
      if (!pwr_fail) begin
         evt_accept = evt_hit;
      end else begin
         unique case (wake.opt)
            WAKE_BY_AUTO_BIT: begin
               evt_accept = evt_hit;
               auto_req   = vdd_rise && wake.auto_on;
            end
            WAKE_NEW_EVT: begin
               evt_accept = evt_hit && vdd_ok;
            end
            WAKE_NEW_OR_MATCH: begin
               evt_accept = evt_hit && vdd_ok;
               auto_req   = vdd_rise && match_lat;
            end
            default: begin
               block_all = 1'b1;
            end
         endcase
      end
   end

   // ---------------- output sequencing ----------------
   logic pend_q, lock_q;
   logic force_off, req, allow;

   assign force_off = ovr_fire || (loss_fire_raw && !ctrl.guard);
   assign req       = evt_accept || auto_req;
   assign allow     = (ctrl.guard || !lock_q || off_done) && !block_all;

   always_ff @(posedge clk or negedge sys_rst_n) begin
      if (!sys_rst_n) begin
         on_q   <= 1'b0;
         pend_q <= 1'b0;
         lock_q <= 1'b0;
      end else if (force_off) begin
         if (on_q) lock_q <= 1'b1;
         on_q   <= 1'b0;
         pend_q <= 1'b0;
      end else if (!on_q && (req || pend_q)) begin
         if (allow) begin
            on_q   <= 1'b1;
            pend_q <= 1'b0;
         end else begin
            pend_q <= 1'b1;
         end
      end
   end

   assign pwr_on = on_q;

   // R4: a completed button hold always leaves the output off
   assert_override_off_R4: assert property (@(posedge clk) disable iff (!sys_rst_n)
      ovr_fire |=> !pwr_on);

   // R8: in guard mode 1 only the button can turn the output off
   assert_guard_keeps_on_R8: assert property (@(posedge clk) disable iff (!sys_rst_n)
      (pwr_on && ctrl.guard && !ovr_fire) |=> pwr_on);

   // R12: wake option 11 blocks every turn-on during a failure
   assert_blocked_policy_R12: assert property (@(posedge clk) disable iff (!sys_rst_n)
      (pwr_fail && wake.opt == WAKE_BLOCKED && !pwr_on) |=> !pwr_on);

   // R11: the match latch never survives a cycle without the failure flag
   assert_match_clears_R11: assert property (@(posedge clk) disable iff (!sys_rst_n)
      !pwr_fail |=> !match_lat);

   // R6: in guard mode 0 a turn-on right after a turn-off is impossible
   assert_min_off_R6: assert property (@(posedge clk) disable iff (!sys_rst_n)
      ($fell(pwr_on) && !ctrl.guard) |=> !pwr_on);

endmodule

// File: tb/pwr_on_seq_bench.sv
module pwr_on_seq_bench;

   localparam int OVR_L = 40;
   localparam int OVR_S = 36;
   localparam int LOSS  = 6;
   localparam int MOFF  = 12;

   logic       clk = 1'b0;
   logic       por_n = 1'b0, mrst_n = 1'b0, tick_ms = 1'b1;
   logic       reg_wr_en = 1'b0, reg_addr = 1'b0;
   logic [7:0] reg_wdata = 8'h00;
   logic       evt_in = 1'b0, btn_in = 1'b0, vdd_ok = 1'b1;
   logic       pwr_fail = 1'b0, match_evt = 1'b0;
   logic       pwr_on;

   always #2 clk = ~clk;   // 250 MHz

   pwr_on_seq #(
      .OVR_LONG_TICKS (OVR_L),
      .OVR_SHORT_TICKS(OVR_S),
      .VDD_LOSS_TICKS (LOSS),
      .MIN_OFF_TICKS  (MOFF),
      .SYNC_STAGES    (2)
   ) u_pwr_on_seq (
      .clk(clk), .por_n(por_n), .mrst_n(mrst_n), .tick_ms(tick_ms),
      .reg_wr_en(reg_wr_en), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
      .evt_in(evt_in), .btn_in(btn_in), .vdd_ok(vdd_ok),
      .pwr_fail(pwr_fail), .match_evt(match_evt), .pwr_on(pwr_on)
   );

   typedef struct {
      int    due;
      logic  exp;
      string tag;
   } item_t;

   item_t sb[$];
   int    cyc    = 0;
   int    checks = 0;
   int    fails  = 0;
   bit    done   = 0;

   // monitor: pops expected items and compares as the design produces them
   always @(posedge clk) begin
      #1;
      cyc++;
      while (sb.size() > 0 && sb[0].due <= cyc) begin
         item_t it;
         it = sb.pop_front();
         checks++;
         if (pwr_on !== it.exp) begin
            fails++;
            $display("FAIL %s: cycle %0d pwr_on=%0b expected %0b", it.tag, cyc, pwr_on, it.exp);
         end
      end
      if (cyc > 100000 && !done) begin
         fails++;
         $display("FAIL watchdog: run did not finish");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

   task automatic expect_at(input int n, input logic v, input string tag);
      sb.push_back('{cyc + n, v, tag});
   endtask

   task automatic wait_cyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic settle();
      while (sb.size() != 0) @(negedge clk);
   endtask

   task automatic wr(input logic a, input logic [7:0] d);
      reg_addr  = a;
      reg_wdata = d;
      reg_wr_en = 1'b1;
      @(negedge clk);
      reg_wr_en = 1'b0;
   endtask

   task automatic force_off(input string tag);
      btn_in = 1'b1;
      wait_cyc(45);
      btn_in = 1'b0;
      expect_at(1, 1'b0, tag);
      settle();
      wait_cyc(4);
   endtask

   initial begin
      wait_cyc(3);
      por_n  = 1'b1;
      mrst_n = 1'b1;
      expect_at(1, 1'b0, "R13 reset state");
      settle();

      // R2 latency and R3 power-up default (either edge)
      evt_in = 1'b1;
      expect_at(2, 1'b0, "R2 sync latency");
      expect_at(3, 1'b1, "R3 default either-edge / R2");
      settle();

      // R4 long override
      btn_in = 1'b1;
      expect_at(OVR_L + 1, 1'b1, "R4 long hold one short");
      expect_at(OVR_L + 2, 1'b0, "R4 long hold off");
      settle();

      // R6 lockout with a held request
      btn_in = 1'b0;
      evt_in = 1'b0;
      expect_at(MOFF, 1'b0, "R6 lockout holds off");
      expect_at(MOFF + 1, 1'b1, "R6 held request granted");
      settle();

      // R8 supply loss with guard 0
      vdd_ok = 1'b0;
      expect_at(LOSS - 1, 1'b1, "R8 loss one short");
      expect_at(LOSS, 1'b0, "R8 loss off");
      settle();
      vdd_ok = 1'b1;

      // R7 guard 1 immediate reassert
      wr(1'b0, 8'h15);
      evt_in = 1'b1;
      expect_at(2, 1'b0, "R7 pre");
      expect_at(3, 1'b1, "R7 immediate reassert");
      settle();

      // R8 guard 1 ignores supply
      vdd_ok = 1'b0;
      expect_at(LOSS * 2, 1'b1, "R8 guard ignores supply");
      settle();
      vdd_ok = 1'b1;

      // R4 short override
      wr(1'b0, 8'h1D);
      btn_in = 1'b1;
      expect_at(OVR_S + 1, 1'b1, "R4 short hold one short");
      expect_at(OVR_S + 2, 1'b0, "R4 short hold off");
      settle();
      btn_in = 1'b0;
      wait_cyc(3);

      // R5 early release restarts
      evt_in = 1'b0;
      expect_at(3, 1'b1, "R5 setup on");
      settle();
      btn_in = 1'b1;
      wait_cyc(20);
      btn_in = 1'b0;
      wait_cyc(4);
      btn_in = 1'b1;
      expect_at(OVR_S + 1, 1'b1, "R5 count restarted");
      expect_at(OVR_S + 2, 1'b0, "R5 off after full hold");
      settle();
      btn_in = 1'b0;
      wait_cyc(4);

      // R1 rising edge
      wr(1'b0, 8'h1C);
      evt_in = 1'b1;
      expect_at(3, 1'b1, "R1 rising fires");
      settle();
      force_off("R1 off");
      evt_in = 1'b0;
      expect_at(4, 1'b0, "R1 falling ignored in rising mode");
      settle();

      // R1 falling edge
      wr(1'b0, 8'h1B);
      evt_in = 1'b1;
      expect_at(4, 1'b0, "R1 rising ignored in falling mode");
      settle();
      evt_in = 1'b0;
      expect_at(3, 1'b1, "R1 falling fires");
      settle();
      force_off("R1 off");

      // R1 reserved codes
      wr(1'b0, 8'h1A);
      evt_in = 1'b1;
      expect_at(4, 1'b0, "R1 code 010 silent");
      settle();
      evt_in = 1'b0;
      expect_at(4, 1'b0, "R1 code 010 silent");
      settle();
      wr(1'b0, 8'h1E);
      evt_in = 1'b1;
      expect_at(4, 1'b0, "R1 code 110 silent");
      settle();
      wr(1'b0, 8'h1F);
      evt_in = 1'b0;
      expect_at(4, 1'b0, "R1 code 111 silent");
      settle();

      // R1 high level
      evt_in = 1'b1;
      wait_cyc(4);
      wr(1'b0, 8'h19);
      expect_at(1, 1'b1, "R1 high level fires");
      settle();
      evt_in = 1'b0;
      wait_cyc(4);
      force_off("R1 off");

      // R1 low level
      wr(1'b0, 8'h18);
      expect_at(1, 1'b1, "R1 low level fires");
      settle();
      wr(1'b0, 8'h1C);
      force_off("R1 off");

      // R12 blocked policy
      pwr_fail = 1'b1;
      wr(1'b1, 8'h03);
      evt_in = 1'b1;
      expect_at(4, 1'b0, "R12 blocked during failure");
      settle();
      evt_in = 1'b0;
      wait_cyc(3);

      // R10 new-event policy
      wr(1'b1, 8'h01);
      vdd_ok = 1'b0;
      evt_in = 1'b1;
      expect_at(4, 1'b0, "R10 event without supply ignored");
      settle();
      evt_in = 1'b0;
      wait_cyc(3);
      vdd_ok = 1'b1;
      expect_at(3, 1'b0, "R10 no auto turn-on");
      settle();
      evt_in = 1'b1;
      expect_at(3, 1'b1, "R10 new event after return");
      settle();
      force_off("R10 off");
      evt_in = 1'b0;
      wait_cyc(3);

      // R11 match latch
      wr(1'b1, 8'h02);
      vdd_ok = 1'b0;
      match_evt = 1'b1;
      wait_cyc(1);
      match_evt = 1'b0;
      wait_cyc(2);
      vdd_ok = 1'b1;
      expect_at(1, 1'b1, "R11 latched match wakes");
      settle();
      force_off("R11 off");
      pwr_fail = 1'b0;
      wait_cyc(3);
      pwr_fail = 1'b1;
      vdd_ok = 1'b0;
      wait_cyc(3);
      vdd_ok = 1'b1;
      expect_at(2, 1'b0, "R11 latch cleared");
      expect_at(5, 1'b0, "R11 latch cleared");
      settle();

      // R9 auto-on bit
      wr(1'b1, 8'h04);
      vdd_ok = 1'b0;
      wait_cyc(3);
      vdd_ok = 1'b1;
      expect_at(1, 1'b1, "R9 auto-on at return");
      settle();
      force_off("R9 off");
      wr(1'b1, 8'h00);
      vdd_ok = 1'b0;
      wait_cyc(3);
      vdd_ok = 1'b1;
      expect_at(2, 1'b0, "R9 waits for event");
      settle();
      evt_in = 1'b1;
      expect_at(3, 1'b1, "R9 event wakes");
      settle();
      force_off("R9 off");
      evt_in = 1'b0;
      pwr_fail = 1'b0;
      wait_cyc(3);

      // R3 / R13 master reset keeps configuration
      mrst_n = 1'b0;
      wait_cyc(2);
      mrst_n = 1'b1;
      expect_at(1, 1'b0, "R13 master reset output low");
      settle();
      evt_in = 1'b1;
      expect_at(3, 1'b1, "R3 trigger kept over master reset");
      settle();
      btn_in = 1'b1;
      expect_at(OVR_S + 1, 1'b1, "R3 short override kept");
      expect_at(OVR_S + 2, 1'b0, "R3 short override kept");
      settle();
      btn_in = 1'b0;
      wait_cyc(4);
      evt_in = 1'b0;
      expect_at(4, 1'b0, "R3 rising-only kept");
      settle();
      evt_in = 1'b1;
      expect_at(3, 1'b1, "R3 guard kept");
      settle();

      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

endmodule